// File: doc/BRIEF.md
# Horizontal Microcoded Datapath Controller

This block is a small datapath run directly by wide horizontal microwords. An internal control store holds the microprogram. Each word carries one independent field per hardware unit: an operand-A transfer, an operand-B transfer, an ALU function, a result transfer and a next-address control. Every unit acts on its own field in the same clock, so one word can move a register into an operand latch, start an ALU operation and store an earlier result all at once. A sequencer fetches one word per clock.

The ALU writes a double-width result as a low half and a high half. Add, subtract and the bitwise functions finish in one cycle. Multiply is iterative. The microprogram must keep it going with a reserved continue code until the full product lands. Program and initial register contents are written through two load ports while reset is held low. The program then runs from address 0 until it reaches a halt word.

Top module: `hucode_engine`

## Requirements
- R1: Each microword takes exactly one clock. A next-address code of 2'b00 advances the micro-PC by one, wrapping at the top of the store.
- R2: An operand transfer field with its enable set loads its latch (A or B) from any general register at the clock edge. With its enable clear, the latch keeps its value.
- R3: ALU codes: 3'b000 none, 3'b001 add, 3'b010 subtract, 3'b100 AND, 3'b101 OR, 3'b110 XOR. Each uses the latched operands as they stand at the start of the cycle. The result appears on res_lo/res_hi one clock after the word issues. For add, the high half is the carry out. For subtract, it is the borrow, which is 1 when A < B. For the bitwise codes, it is zero.
- R4: Code 3'b011 starts an unsigned 16x16 multiply. The code must be followed by exactly three words with code 3'b111 (continue). The 32-bit product appears one clock after the third continue. busy is high for those three continue cycles, and the result halves keep their old value until the product lands.
- R5: If any code other than 3'b111 issues while busy is high, err is set and stays set until reset. The multiply is abandoned and the new code executes normally.
- R6: With its enable set, the result transfer field writes the low half (half select 0) or the high half (select 1) into the named register at the end of the cycle. An operand read of that register in the same word returns the value it held before the write.
- R7: Next-address code 2'b01 jumps to the 8-bit target. Code 2'b10 jumps to the target only when res_lo, as seen during that word, is zero; otherwise it advances. Words that are jumped over have no effect.
- R8: Next-address code 2'b11 halts. The halt word's own fields take effect. After that, halted stays high, the micro-PC stays on the halt word, and no unit changes.
- R9: While rst_n is low: upc, halted, busy, err, res_lo and res_hi are zero, and the control-store and register load ports write. While rst_n is high, both load ports are ignored.
- R10: A continue code with no multiply in progress, and the 3'b000 code, leave the result halves unchanged.
- R11: Microword bit layout at default sizes (29 bits): [28] A enable, [27:24] A register, [23] B enable, [22:19] B register, [18:16] ALU code, [15] result write enable, [14] half select, [13:10] destination register, [9:8] next-address code, [7:0] target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loading happens while low |
| cs_we | input | 1 | Control-store write strobe (honoured only in reset) |
| cs_addr | input | 8 | Control-store write address |
| cs_wdata | input | 29 | Microword to store |
| rf_we | input | 1 | Register preload strobe (honoured only in reset) |
| rf_addr | input | 4 | Register preload address |
| rf_wdata | input | 16 | Register preload data |
| obs_addr | input | 4 | Register observation address |
| obs_data | output | 16 | Contents of the observed register |
| upc | output | 8 | Current micro-PC |
| halted | output | 1 | Program has reached a halt word |
| busy | output | 1 | Multiply in progress |
| err | output | 1 | Sticky: new ALU code issued while busy |
| res_lo | output | 16 | Low result half |
| res_hi | output | 16 | High result half |

## Verification
A single-cycle ALU result is due on the result halves one edge after its word, so the bench's programs always store it with the following word. A multiply's product is due one edge after its third continue, and the bench's programs store it only after that edge. A conditional jump tests the result of the previous word, and the jump programs are laid out to match that timing. The bench drives and samples on falling edges. It counts busy cycles at every falling edge during a run, reads the registers only after halted rises, and then holds for further cycles to confirm that nothing moves.

// File: rtl/hucode_pkg.sv
// Shared encodings for the horizontal microcoded datapath.
// Assumes a 3-bit ALU code and a 2-bit next-address code per microword.
package hucode_pkg;

    typedef enum logic [2:0] {
        FN_NOP  = 3'b000,
        FN_ADD  = 3'b001,
        FN_SUB  = 3'b010,
        FN_MUL  = 3'b011,
        FN_AND  = 3'b100,
        FN_OR   = 3'b101,
        FN_XOR  = 3'b110,
        FN_CONT = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        SQ_NEXT = 2'b00,
        SQ_JUMP = 2'b01,
        SQ_JZ   = 2'b10,
        SQ_HALT = 2'b11
    } seq_e;

endpackage

// File: rtl/hucode_regfile.sv
// General register file: three asynchronous read ports and one write port.
// The write lands at the clock edge, so a same-cycle read returns the old value.
// The preload port writes only while reset is low. The normal write port
// writes only while reset is high. There is no reset of the contents.
module hucode_regfile #(
    parameter int W = 16,
    parameter int N = 16,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_data,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd3
);

    logic [W-1:0] mem [N];

    // Storage update: preload in reset, datapath write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (ld_we) mem[ld_addr] <= ld_data;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read ports see the stored (pre-write) contents.
    always_comb begin
        rd1 = mem[ra1];
        rd2 = mem[ra2];
        rd3 = mem[ra3];
    end

    // R6: a datapath write is visible in the named register one edge later.
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/hucode_alu.sv
// ALU with low and high result halves. Single-cycle ops finish at the issue
// edge. Multiply retires DIG multiplier bits per cycle over MUL_CYC cycles
// and needs MUL_CYC-1 continue codes after the issue.
// Assumes W is divisible by MUL_CYC and MUL_CYC >= 2.
module hucode_alu
    import hucode_pkg::*;
#(
    parameter int W       = 16,
    parameter int MUL_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  alu_fn_e      fn_i,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi,
    output logic         busy,
    output logic         err
);

    localparam int DIG = W / MUL_CYC;
    localparam int SW  = $clog2(MUL_CYC);
    localparam int PW  = 2 * W;
    localparam logic [SW-1:0] LAST = SW'(MUL_CYC - 1);

    logic [PW-1:0] acc_q, mcand_q, acc_step, part0;
    logic [W-1:0]  mplr_q;
    logic [SW-1:0] step_q;
    logic [W:0]    sum, dif;
    logic          cont, start;

    // Arithmetic for the next multiply step and the single-cycle ops.
    always_comb begin
        acc_step = acc_q + mcand_q * PW'(mplr_q[DIG-1:0]);
        part0    = PW'(opa) * PW'(opb[DIG-1:0]);
        sum      = {1'b0, opa} + {1'b0, opb};
        dif      = {1'b0, opa} - {1'b0, opb};
        cont     = go && busy && (fn_i == FN_CONT);
        start    = go && (fn_i != FN_CONT);
    end

    // Result, multiply progress and error tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo  <= '0;
            res_hi  <= '0;
            busy    <= 1'b0;
            err     <= 1'b0;
            acc_q   <= '0;
            mcand_q <= '0;
            mplr_q  <= '0;
            step_q  <= '0;
        end else if (cont) begin
            acc_q   <= acc_step;
            mcand_q <= mcand_q << DIG;
            mplr_q  <= mplr_q >> DIG;
            step_q  <= step_q + SW'(1);
            if (step_q == LAST) begin
                res_lo <= acc_step[W-1:0];
                res_hi <= acc_step[PW-1:W];
                busy   <= 1'b0;
            end
        end else if (start) begin
            if (busy) err <= 1'b1;
            busy <= 1'b0;
            case (fn_i)
                FN_ADD: begin res_lo <= sum[W-1:0]; res_hi <= W'(sum[W]); end
                FN_SUB: begin res_lo <= dif[W-1:0]; res_hi <= W'(dif[W]); end
                FN_AND: begin res_lo <= opa & opb;  res_hi <= '0; end
                FN_OR:  begin res_lo <= opa | opb;  res_hi <= '0; end
                FN_XOR: begin res_lo <= opa ^ opb;  res_hi <= '0; end
                FN_MUL: begin
                    acc_q   <= part0;
                    mcand_q <= PW'(opa) << DIG;
                    mplr_q  <= opb >> DIG;
                    step_q  <= SW'(1);
                    busy    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R5: the error flag never clears outside reset.
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R4: an intermediate continue leaves the result halves alone and stays busy.
    a_r4_partial_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && step_q != LAST) |=> ($stable(res_lo) && $stable(res_hi) && busy));

    // R3: single-cycle codes never leave the unit busy.
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (fn_i == FN_ADD || fn_i == FN_SUB || fn_i == FN_AND ||
                fn_i == FN_OR || fn_i == FN_XOR)) |=> !busy);

    // R10: the none code and an idle continue keep the result halves.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && (fn_i == FN_NOP || fn_i == FN_CONT)) |=>
            ($stable(res_lo) && $stable(res_hi)));

endmodule

// File: rtl/hucode_seq.sv
// Microsequencer: holds the micro-PC and the halt flag and picks the next
// address from the word's next-address code.
// Assumes lo_zero reflects the result halves as they stand during this word.
module hucode_seq
    import hucode_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_e          seq_i,
    input  logic [AW-1:0] target,
    input  logic          lo_zero,
    output logic [AW-1:0] upc,
    output logic          halted
);

    // Next-address selection, frozen once halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc    <= '0;
            halted <= 1'b0;
        end else if (!halted) begin
            case (seq_i)
                SQ_NEXT: upc <= upc + AW'(1);
                SQ_JUMP: upc <= target;
                SQ_JZ:   upc <= lo_zero ? target : upc + AW'(1);
                default: halted <= 1'b1;
            endcase
        end
    end

    // R1: a plain step advances by one.
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && seq_i == SQ_NEXT) |=> (upc == AW'($past(upc) + AW'(1))));

    // R7: an unconditional jump reaches its target.
    a_r7_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && seq_i == SQ_JUMP) |=> (upc == $past(target)));

    // R8: after halting the PC and flag hold.
    a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(upc)));

endmodule

// File: rtl/hucode_engine.sv
// Top of the horizontal microcoded datapath. It holds the control store and
// the operand latches, decodes the fields of the current microword and
// drives the register file, the ALU and the sequencer in parallel.
// Assumes the control store and registers are loaded while rst_n is low.
module hucode_engine
    import hucode_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_N   = 16,
    parameter int CS_AW   = 8,
    parameter int MUL_CYC = 4,
    localparam int RA_W   = $clog2(REG_N),
    localparam int CW     = 3 * RA_W + CS_AW + 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_we,
    input  logic [CS_AW-1:0]  cs_addr,
    input  logic [CW-1:0]     cs_wdata,
    input  logic              rf_we,
    input  logic [RA_W-1:0]   rf_addr,
    input  logic [DATA_W-1:0] rf_wdata,
    input  logic [RA_W-1:0]   obs_addr,
    output logic [DATA_W-1:0] obs_data,
    output logic [CS_AW-1:0]  upc,
    output logic              halted,
    output logic              busy,
    output logic              err,
    output logic [DATA_W-1:0] res_lo,
    output logic [DATA_W-1:0] res_hi
);

    localparam int DEPTH = 2 ** CS_AW;
    localparam int TG_LO = 0;
    localparam int SQ_LO = CS_AW;
    localparam int WR_LO = CS_AW + 2;
    localparam int WH_B  = WR_LO + RA_W;
    localparam int WE_B  = WH_B + 1;
    localparam int FN_LO = WE_B + 1;
    localparam int BR_LO = FN_LO + 3;
    localparam int BE_B  = BR_LO + RA_W;
    localparam int AR_LO = BE_B + 1;
    localparam int AE_B  = AR_LO + RA_W;

    logic [CW-1:0]     cs_mem [DEPTH];
    logic [CW-1:0]     uw;
    logic              a_en, b_en, w_en, w_half, go;
    logic [RA_W-1:0]   a_reg, b_reg, w_reg;
    alu_fn_e           fn;
    seq_e              sq;
    logic [CS_AW-1:0]  tgt;
    logic [DATA_W-1:0] rd_a, rd_b, op_a, op_b, wdata;

    // Control-store load, honoured only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n && cs_we) cs_mem[cs_addr] <= cs_wdata;
    end

    // Field decode of the word at the micro-PC.
    always_comb begin
        uw     = cs_mem[upc];
        a_en   = uw[AE_B];
        a_reg  = uw[AR_LO +: RA_W];
        b_en   = uw[BE_B];
        b_reg  = uw[BR_LO +: RA_W];
        fn     = alu_fn_e'(uw[FN_LO +: 3]);
        w_en   = uw[WE_B];
        w_half = uw[WH_B];
        w_reg  = uw[WR_LO +: RA_W];
        sq     = seq_e'(uw[SQ_LO +: 2]);
        tgt    = uw[TG_LO +: CS_AW];
        go     = !halted;
        wdata  = w_half ? res_hi : res_lo;
    end

    // Operand latches: each loads from the register file when its field is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
        end else begin
            if (go && a_en) op_a <= rd_a;
            if (go && b_en) op_b <= rd_b;
        end
    end

    hucode_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_we   (rf_we),
        .ld_addr (rf_addr),
        .ld_data (rf_wdata),
        .we      (go && w_en),
        .waddr   (w_reg),
        .wdata   (wdata),
        .ra1     (a_reg),
        .rd1     (rd_a),
        .ra2     (b_reg),
        .rd2     (rd_b),
        .ra3     (obs_addr),
        .rd3     (obs_data)
    );

    hucode_alu #(.W(DATA_W), .MUL_CYC(MUL_CYC)) u_alu (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .fn_i   (fn),
        .opa    (op_a),
        .opb    (op_b),
        .res_lo (res_lo),
        .res_hi (res_hi),
        .busy   (busy),
        .err    (err)
    );

    hucode_seq #(.AW(CS_AW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .seq_i   (sq),
        .target  (tgt),
        .lo_zero (res_lo == '0),
        .upc     (upc),
        .halted  (halted)
    );

    // R2: a latch without an enabled transfer keeps its value.
    a_r2_opa_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && a_en) |=> $stable(op_a));
    a_r2_opb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && b_en) |=> $stable(op_b));

    // R8: once halted, no result half changes.
    a_r8_results_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(res_lo) && $stable(res_hi)));

endmodule

// File: tb/hucode_engine_bench.sv
`timescale 1ns/1ps
module hucode_engine_bench;

    localparam int CW = 29;
    localparam logic [2:0] F_NOP = 3'b000, F_ADD = 3'b001, F_SUB = 3'b010, F_MUL = 3'b011,
                           F_AND = 3'b100, F_OR = 3'b101, F_XOR = 3'b110, F_CONT = 3'b111;
    localparam logic [1:0] S_NX = 2'b00, S_JP = 2'b01, S_JZ = 2'b10, S_HT = 2'b11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_we = 1'b0, rf_we = 1'b0;
    logic [7:0] cs_addr = '0;
    logic [CW-1:0] cs_wdata = '0;
    logic [3:0] rf_addr = '0, obs_addr = '0;
    logic [15:0] rf_wdata = '0, obs_data, res_lo, res_hi;
    logic [7:0] upc;
    logic halted, busy, err;

    hucode_engine u_hucode_engine (
        .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_addr(cs_addr), .cs_wdata(cs_wdata),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .obs_addr(obs_addr),
        .obs_data(obs_data), .upc(upc), .halted(halted), .busy(busy), .err(err),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, busy_cycles = 0;
    bit count_en = 1'b0;
    logic [CW-1:0] prog [16];
    int prog_len = 0;

    always @(negedge clk) if (count_en && busy) busy_cycles++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung actual=%0d expected<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Microword per R11 layout.
    function automatic logic [CW-1:0] mk(input logic ae, input logic [3:0] ar, input logic be,
        input logic [3:0] br, input logic [2:0] fn, input logic we, input logic wh,
        input logic [3:0] wr, input logic [1:0] sq, input logic [7:0] t);
        return {ae, ar, be, br, fn, we, wh, wr, sq, t};
    endfunction

    task automatic load_cs();
        for (int i = 0; i < prog_len; i++) begin
            @(negedge clk); cs_we = 1'b1; cs_addr = 8'(i); cs_wdata = prog[i];
        end
        @(negedge clk); cs_we = 1'b0;
    endtask

    task automatic load_rf(input int r, input logic [15:0] v);
        @(negedge clk); rf_we = 1'b1; rf_addr = 4'(r); rf_wdata = v;
        @(negedge clk); rf_we = 1'b0;
    endtask

    task automatic rd(input int r, output logic [15:0] v);
        obs_addr = 4'(r); #1; v = obs_data;
    endtask

    task automatic run();
        @(negedge clk); rst_n = 1'b1;
        busy_cycles = 0; count_en = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        count_en = 1'b0;
        chk("R8", "halted reached", {31'b0, halted}, 32'd1);
    endtask

    task automatic reset_check();
        chk("R9", "reset upc", {24'b0, upc}, 32'd0);
        chk("R9", "reset flags", {29'b0, halted, busy, err}, 32'd0);
        chk("R9", "reset results", {res_hi, res_lo}, 32'd0);
    endtask

    task automatic build_p();
        prog[0]  = mk(1, 1, 1, 2, F_NOP,  0, 0, 0,  S_NX, 0);
        prog[1]  = mk(0, 0, 0, 0, F_ADD,  0, 0, 0,  S_NX, 0);
        prog[2]  = mk(0, 0, 0, 0, F_SUB,  1, 0, 3,  S_NX, 0);
        prog[3]  = mk(0, 0, 0, 0, F_AND,  1, 0, 4,  S_NX, 0);
        prog[4]  = mk(0, 0, 0, 0, F_OR,   1, 0, 5,  S_NX, 0);
        prog[5]  = mk(0, 0, 0, 0, F_XOR,  1, 0, 6,  S_NX, 0);
        prog[6]  = mk(0, 0, 0, 0, F_MUL,  1, 0, 7,  S_NX, 0);
        prog[7]  = mk(0, 0, 0, 0, F_CONT, 0, 0, 0,  S_NX, 0);
        prog[8]  = mk(0, 0, 0, 0, F_CONT, 0, 0, 0,  S_NX, 0);
        prog[9]  = mk(0, 0, 0, 0, F_CONT, 0, 0, 0,  S_NX, 0);
        prog[10] = mk(0, 0, 0, 0, F_CONT, 1, 0, 8,  S_NX, 0);
        prog[11] = mk(0, 0, 0, 0, F_ADD,  1, 1, 9,  S_NX, 0);
        prog[12] = mk(1, 10, 0, 0, F_NOP, 1, 1, 10, S_NX, 0);
        prog[13] = mk(0, 0, 0, 0, F_OR,   0, 0, 0,  S_NX, 0);
        prog[14] = mk(0, 0, 0, 0, F_NOP,  1, 0, 11, S_HT, 0);
        prog_len = 15;
    endtask

    task automatic check_p(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        logic [15:0] v;
        logic [31:0] p, s;
        p = {16'b0, a} * {16'b0, b};
        s = {16'b0, a} + {16'b0, b};
        chk("R1", "halt address", {24'b0, upc}, 32'd14);
        rd(3, v);  chk("R3", "add low", {16'b0, v}, {16'b0, s[15:0]});
        rd(4, v);  chk("R3", "sub low", {16'b0, v}, {16'b0, 16'(a - b)});
        rd(5, v);  chk("R3", "and", {16'b0, v}, {16'b0, a & b});
        rd(6, v);  chk("R3", "or", {16'b0, v}, {16'b0, a | b});
        rd(7, v);  chk("R3", "xor", {16'b0, v}, {16'b0, a ^ b});
        rd(8, v);  chk("R4", "product low", {16'b0, v}, {16'b0, p[15:0]});
        rd(9, v);  chk("R10", "product high kept across idle continue", {16'b0, v}, {16'b0, p[31:16]});
        rd(10, v); chk("R6", "carry via high half", {16'b0, v}, {16'b0, s[31:16]});
        rd(11, v); chk("R6", "same-cycle read saw old value; R2 B latch held", {16'b0, v}, {16'b0, c | b});
        chk("R3", "final result halves", {res_hi, res_lo}, {16'b0, c | b});
        chk("R4", "busy cycle count", 32'(busy_cycles), 32'd3);
        chk("R5", "no error on legal program", {31'b0, err}, 32'd0);
    endtask

    task automatic do_p(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        rst_n = 1'b0;
        build_p(); load_cs();
        load_rf(1, a); load_rf(2, b); load_rf(10, c);
        reset_check();
        run();
        check_p(a, b, c);
    endtask

    task automatic do_j(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] v;
        rst_n = 1'b0;
        prog[0] = mk(1, 1, 1, 2, F_NOP, 0, 0, 0, S_NX, 0);
        prog[1] = mk(0, 0, 0, 0, F_SUB, 0, 0, 0, S_NX, 0);
        prog[2] = mk(0, 0, 0, 0, F_NOP, 0, 0, 0, S_JZ, 5);
        prog[3] = mk(1, 5, 1, 0, F_NOP, 0, 0, 0, S_JP, 6);
        prog[4] = mk(0, 0, 0, 0, F_NOP, 1, 0, 8, S_NX, 0);
        prog[5] = mk(1, 6, 1, 0, F_NOP, 0, 0, 0, S_NX, 0);
        prog[6] = mk(0, 0, 0, 0, F_OR,  0, 0, 0, S_NX, 0);
        prog[7] = mk(0, 0, 0, 0, F_NOP, 1, 0, 7, S_HT, 0);
        prog_len = 8;
        load_cs();
        load_rf(0, 16'h0000); load_rf(1, a); load_rf(2, b);
        load_rf(5, 16'h1111); load_rf(6, 16'h2222); load_rf(8, 16'hDEAD);
        run();
        rd(7, v); chk("R7", "branch path result", {16'b0, v}, (a == b) ? 32'h2222 : 32'h1111);
        rd(8, v); chk("R7", "skipped word had no effect", {16'b0, v}, 32'hDEAD);
        chk("R7", "halt address", {24'b0, upc}, 32'd7);
    endtask

    task automatic do_e(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] v;
        logic [31:0] s;
        s = {16'b0, a} + {16'b0, b};
        rst_n = 1'b0;
        prog[0] = mk(1, 1, 1, 2, F_NOP, 0, 0, 0, S_NX, 0);
        prog[1] = mk(0, 0, 0, 0, F_MUL, 0, 0, 0, S_NX, 0);
        prog[2] = mk(0, 0, 0, 0, F_ADD, 0, 0, 0, S_NX, 0);
        prog[3] = mk(0, 0, 0, 0, F_NOP, 1, 0, 3, S_HT, 0);
        prog_len = 4;
        load_cs();
        load_rf(1, a); load_rf(2, b);
        run();
        chk("R5", "error raised", {31'b0, err}, 32'd1);
        chk("R5", "multiply abandoned", {31'b0, busy}, 32'd0);
        rd(3, v); chk("R5", "interrupting add executed", {16'b0, v}, {16'b0, s[15:0]});
        repeat (3) @(negedge clk);
        chk("R5", "error stays set", {31'b0, err}, 32'd1);
    endtask

    logic [15:0] vals [8];

    initial begin
        logic [15:0] v, lo0, u0;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h8000;
        vals[4] = 16'h7FFF; vals[5] = 16'h1234; vals[6] = 16'hABCD; vals[7] = 16'h00FF;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                do_p(vals[i], vals[j], 16'h4000 ^ 16'(i * 16'h0111 + j));

        // R8: nothing moves after halt.
        u0 = {8'b0, upc}; lo0 = res_lo;
        repeat (4) @(negedge clk);
        chk("R8", "upc frozen", {24'b0, upc}, {16'b0, u0});
        chk("R8", "still halted", {31'b0, halted}, 32'd1);
        chk("R8", "result frozen", {16'b0, res_lo}, {16'b0, lo0});
        rd(11, v); chk("R8", "register frozen", {16'b0, v}, {16'b0, lo0});

        // R9: load ports ignored while running; then rerun without reloading the store.
        @(negedge clk);
        rf_we = 1'b1; rf_addr = 4'd1; rf_wdata = ~vals[7];
        cs_we = 1'b1; cs_addr = 8'd13; cs_wdata = mk(0, 0, 0, 0, F_ADD, 0, 0, 0, S_NX, 0);
        @(negedge clk); rf_we = 1'b0; cs_we = 1'b0;
        rd(1, v); chk("R9", "register preload ignored out of reset", {16'b0, v}, {16'b0, vals[7]});
        rst_n = 1'b0;
        load_rf(10, 16'h0C30);
        run();
        rd(11, v); chk("R9", "store write ignored out of reset", {16'b0, v}, {16'b0, 16'h0C30 | vals[7]});

        for (int i = 0; i < 8; i++) begin
            do_j(vals[i], vals[i]);
            do_j(vals[i], vals[(i + 1) % 8]);
        end
        for (int i = 0; i < 4; i++) do_e(vals[i + 2], vals[7 - i]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule